// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block turns a load/store addressing request into an effective address for the data space, the I/O space or program memory. It reads three 16-bit pointers (X, held in register pair R27:R26; Y in R29:R28; Z in R31:R30), a 6-bit displacement, a 16-bit direct address taken from the second instruction word, a 6-bit I/O address and an 8-bit extension register. It returns the effective address, the address space it belongs to, a byte-select bit for program-memory reads and, for the auto-modifying modes, the new pointer value with a write-back strobe. The register file and memories are outside the block.

A request is a one-cycle `req` pulse with a mode code. A small controller moves through four named states. `ST_IDLE` waits for a request. Idle to `ST_ISSUE` happens when the request is legal, and idle to `ST_REJECT` happens when it is not. `ST_ISSUE` presents the address for one cycle and then goes to `ST_WBACK` if the mode modifies a pointer, or back to `ST_IDLE` if it does not. `ST_WBACK` presents the pointer write-back for one cycle and returns to `ST_IDLE`. `ST_REJECT` raises `req_err` for one cycle and returns to `ST_IDLE`. The pointers feed the address arithmetic in the cycle of the request. The write-back therefore lands one cycle after the address.

Top module: `ptr_agen`

## Requirements
- R1: While idle, and after reset, `addr_valid`, `ptr_we` and `req_err` are 0, `eff_addr`, `ptr_wsel` and `ptr_wdata` are 0, `byte_hi` is 0, and `addr_space` is 0 (none).
- R2: Mode 0 (plain indirect) gives `eff_addr` = the selected pointer, with `ptr_sel` 0 = X, 1 = Y, 2 = Z. `addr_space` is 1 (data) and there is no write-back.
- R3: Mode 1 (displacement) gives `eff_addr` = (Y or Z) + unsigned 6-bit `disp`, modulo 2^16. Using X with this mode is illegal.
- R4: Mode 2 (pre-decrement) gives `eff_addr` = pointer − 1 modulo 2^16. In the following cycle the same value is written back to the same pointer, so 0x0000 becomes 0xFFFF.
- R5: Mode 3 (post-increment) gives `eff_addr` = the unmodified pointer. In the following cycle pointer + 1 modulo 2^16 is written back, so 0xFFFF becomes 0x0000.
- R6: Mode 4 (direct) gives `eff_addr` = `direct_addr` with `addr_space` 1. Mode 5 (I/O direct) gives `eff_addr` = `io_addr` (0–63) with `addr_space` 2 (I/O). Neither mode writes back.
- R7: Modes 6 and 7 (program-memory read) give `eff_addr` = Z[15:1] as a word address and `byte_hi` = Z[0], with `addr_space` 3 (program). `ext_reg` has no effect. `ptr_sel` has no effect in modes 4–9.
- R8: Modes 8 and 9 (extended program-memory read) give `eff_addr` = {`ext_reg`, Z[15:1]}. Modes 7 and 9 write back Z + 1 modulo 2^16 with `ptr_wsel` = 2. The extension register is never written.
- R9: `addr_valid` is high for exactly the one cycle after the clock edge that accepts a request. `ptr_we` is high only in the cycle right after `addr_valid`, and only for modes 2, 3, 7 and 9.
- R10: A `req` seen while the block is not idle is ignored.
- R11: Mode codes 10–15, and `ptr_sel` = 3 in modes 0–3, are illegal. Such a request raises `req_err` for one cycle in place of `addr_valid`, with no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request pulse, accepted only when idle |
| mode | input | 4 | Addressing mode code |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| ptr_x | input | 16 | X pointer (R27:R26) |
| ptr_y | input | 16 | Y pointer (R29:R28) |
| ptr_z | input | 16 | Z pointer (R31:R30) |
| disp | input | 6 | Unsigned displacement |
| direct_addr | input | 16 | Direct address from second instruction word |
| io_addr | input | 6 | I/O direct address |
| ext_reg | input | 8 | Extension register for program reads |
| addr_valid | output | 1 | Effective address valid |
| eff_addr | output | 23 | Effective address (word address for program space) |
| addr_space | output | 2 | 0 none, 1 data, 2 I/O, 3 program |
| byte_hi | output | 1 | Program read selects the high byte |
| ptr_we | output | 1 | Pointer write-back strobe |
| ptr_wsel | output | 2 | Pointer being written back |
| ptr_wdata | output | 16 | New pointer value |
| req_err | output | 1 | Illegal request flagged |

## Verification
The assertions assume that `req` only starts a request from the idle state. They check the write-back against the address presented one cycle earlier, so they rely on the pointer arithmetic being captured at acceptance rather than read again later. The stimulus pulses `req` for one cycle and lets each request finish before the next. The exception is one directed case that holds `req` high during an issue cycle to show it is ignored. Random requests cover all sixteen mode codes and all four select values, so illegal combinations are exercised alongside legal ones.

// File: rtl/agen_pkg.sv
package agen_pkg;

    typedef enum logic [3:0] {
        M_IND      = 4'd0,
        M_DISP     = 4'd1,
        M_PREDEC   = 4'd2,
        M_POSTINC  = 4'd3,
        M_DIRECT   = 4'd4,
        M_IODIR    = 4'd5,
        M_PM       = 4'd6,
        M_PM_INC   = 4'd7,
        M_PMX      = 4'd8,
        M_PMX_INC  = 4'd9
    } amode_e;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_DATA = 2'd1,
        SP_IO   = 2'd2,
        SP_PROG = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WBACK  = 2'd2,
        ST_REJECT = 2'd3
    } agen_st_e;

    localparam logic [1:0] PSEL_X = 2'd0;
    localparam logic [1:0] PSEL_Y = 2'd1;
    localparam logic [1:0] PSEL_Z = 2'd2;
    localparam int         NUM_PTRS = 3;

endpackage

// File: rtl/agen_ptr_mux.sv
module agen_ptr_mux
    import agen_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic [PTR_W-1:0] ptr_x,
    input  logic [PTR_W-1:0] ptr_y,
    input  logic [PTR_W-1:0] ptr_z,
    input  logic [1:0]       sel,
    output logic [PTR_W-1:0] ptr,
    output logic             sel_ok
);
    logic [PTR_W-1:0] bank [NUM_PTRS];
    logic [NUM_PTRS-1:0] hit;

    assign bank[0] = ptr_x;
    assign bank[1] = ptr_y;
    assign bank[2] = ptr_z;

    for (genvar g = 0; g < NUM_PTRS; g++) begin : g_hit
        assign hit[g] = (sel == 2'(g));
    end

    always_comb begin
        ptr = '0;
        for (int i = 0; i < NUM_PTRS; i++) begin
            if (hit[i]) ptr = bank[i];
        end
    end

    assign sel_ok = |hit;
endmodule

// File: rtl/agen_calc.sv
module agen_calc
    import agen_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int DISP_W = 6,
    parameter int IO_W   = 6,
    parameter int EXT_W  = 8,
    parameter int ADDR_W = EXT_W + PTR_W - 1
) (
    input  logic [3:0]        mode,
    input  logic [1:0]        sel,
    input  logic              sel_ok,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [PTR_W-1:0]  ptr_z,
    input  logic [DISP_W-1:0] disp,
    input  logic [PTR_W-1:0]  direct_addr,
    input  logic [IO_W-1:0]   io_addr,
    input  logic [EXT_W-1:0]  ext_reg,
    output logic              ok,
    output logic [ADDR_W-1:0] addr,
    output space_e            space,
    output logic              byte_hi,
    output logic              wb_need,
    output logic [1:0]        wb_sel,
    output logic [PTR_W-1:0]  wb_data
);
    logic [PTR_W-1:0] ptr_dec, ptr_inc, ptr_off, z_inc;
    logic [ADDR_W-1:0] pm_word, pmx_word;

    assign ptr_dec  = ptr - PTR_W'(1);
    assign ptr_inc  = ptr + PTR_W'(1);
    assign ptr_off  = ptr + PTR_W'(disp);
    assign z_inc    = ptr_z + PTR_W'(1);
    assign pm_word  = {{EXT_W{1'b0}}, ptr_z[PTR_W-1:1]};
    assign pmx_word = {ext_reg, ptr_z[PTR_W-1:1]};

    always_comb begin
        ok      = 1'b0;
        addr    = '0;
        space   = SP_NONE;
        byte_hi = 1'b0;
        wb_need = 1'b0;
        wb_sel  = '0;
        wb_data = '0;
        case (amode_e'(mode))
            M_IND: begin
                ok    = sel_ok;
                addr  = ADDR_W'(ptr);
                space = SP_DATA;
            end
            M_DISP: begin
                ok    = sel_ok && (sel != PSEL_X);
                addr  = ADDR_W'(ptr_off);
                space = SP_DATA;
            end
            M_PREDEC: begin
                ok      = sel_ok;
                addr    = ADDR_W'(ptr_dec);
                space   = SP_DATA;
                wb_need = sel_ok;
                wb_sel  = sel;
                wb_data = ptr_dec;
            end
            M_POSTINC: begin
                ok      = sel_ok;
                addr    = ADDR_W'(ptr);
                space   = SP_DATA;
                wb_need = sel_ok;
                wb_sel  = sel;
                wb_data = ptr_inc;
            end
            M_DIRECT: begin
                ok    = 1'b1;
                addr  = ADDR_W'(direct_addr);
                space = SP_DATA;
            end
            M_IODIR: begin
                ok    = 1'b1;
                addr  = ADDR_W'(io_addr);
                space = SP_IO;
            end
            M_PM, M_PM_INC: begin
                ok      = 1'b1;
                addr    = pm_word;
                space   = SP_PROG;
                byte_hi = ptr_z[0];
                wb_need = (amode_e'(mode) == M_PM_INC);
                wb_sel  = wb_need ? PSEL_Z : 2'd0;
                wb_data = wb_need ? z_inc : '0;
            end
            M_PMX, M_PMX_INC: begin
                ok      = 1'b1;
                addr    = pmx_word;
                space   = SP_PROG;
                byte_hi = ptr_z[0];
                wb_need = (amode_e'(mode) == M_PMX_INC);
                wb_sel  = wb_need ? PSEL_Z : 2'd0;
                wb_data = wb_need ? z_inc : '0;
            end
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/agen_ctrl.sv
module agen_ctrl
    import agen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req,
    input  logic     req_ok,
    input  logic     wb_pending,
    output agen_st_e state,
    output logic     accept
);
    agen_st_e nxt;

    assign accept = (state == ST_IDLE) && req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req) nxt = req_ok ? ST_ISSUE : ST_REJECT;
            ST_ISSUE:  nxt = wb_pending ? ST_WBACK : ST_IDLE;
            ST_WBACK:  nxt = ST_IDLE;
            ST_REJECT: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
    import agen_pkg::*;
#(
    parameter  int PTR_W  = 16,
    parameter  int DISP_W = 6,
    parameter  int IO_W   = 6,
    parameter  int EXT_W  = 8,
    localparam int ADDR_W = EXT_W + PTR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [3:0]        mode,
    input  logic [1:0]        ptr_sel,
    input  logic [PTR_W-1:0]  ptr_x,
    input  logic [PTR_W-1:0]  ptr_y,
    input  logic [PTR_W-1:0]  ptr_z,
    input  logic [DISP_W-1:0] disp,
    input  logic [PTR_W-1:0]  direct_addr,
    input  logic [IO_W-1:0]   io_addr,
    input  logic [EXT_W-1:0]  ext_reg,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [1:0]        addr_space,
    output logic              byte_hi,
    output logic              ptr_we,
    output logic [1:0]        ptr_wsel,
    output logic [PTR_W-1:0]  ptr_wdata,
    output logic              req_err
);
    logic [PTR_W-1:0]  sel_ptr;
    logic              sel_ok;
    logic              c_ok, c_hi, c_wb;
    logic [ADDR_W-1:0] c_addr;
    space_e            c_space;
    logic [1:0]        c_wsel;
    logic [PTR_W-1:0]  c_wdata;

    agen_st_e          state;
    logic              accept;

    logic [ADDR_W-1:0] r_addr;
    space_e            r_space;
    logic              r_hi, r_wb;
    logic [1:0]        r_wsel;
    logic [PTR_W-1:0]  r_wdata;
    logic [3:0]        r_mode;
    logic [1:0]        r_sel;

    agen_ptr_mux #(.PTR_W(PTR_W)) u_mux (
        .ptr_x  (ptr_x),
        .ptr_y  (ptr_y),
        .ptr_z  (ptr_z),
        .sel    (ptr_sel),
        .ptr    (sel_ptr),
        .sel_ok (sel_ok)
    );

    agen_calc #(
        .PTR_W(PTR_W), .DISP_W(DISP_W), .IO_W(IO_W), .EXT_W(EXT_W), .ADDR_W(ADDR_W)
    ) u_calc (
        .mode        (mode),
        .sel         (ptr_sel),
        .sel_ok      (sel_ok),
        .ptr         (sel_ptr),
        .ptr_z       (ptr_z),
        .disp        (disp),
        .direct_addr (direct_addr),
        .io_addr     (io_addr),
        .ext_reg     (ext_reg),
        .ok          (c_ok),
        .addr        (c_addr),
        .space       (c_space),
        .byte_hi     (c_hi),
        .wb_need     (c_wb),
        .wb_sel      (c_wsel),
        .wb_data     (c_wdata)
    );

    agen_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_ok     (c_ok),
        .wb_pending (r_wb),
        .state      (state),
        .accept     (accept)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_addr  <= '0;
            r_space <= SP_NONE;
            r_hi    <= 1'b0;
            r_wb    <= 1'b0;
            r_wsel  <= '0;
            r_wdata <= '0;
            r_mode  <= '0;
            r_sel   <= '0;
        end else if (accept) begin
            r_addr  <= c_addr;
            r_space <= c_space;
            r_hi    <= c_hi;
            r_wb    <= c_ok && c_wb;
            r_wsel  <= c_wsel;
            r_wdata <= c_wdata;
            r_mode  <= mode;
            r_sel   <= ptr_sel;
        end
    end

    always_comb begin
        addr_valid = 1'b0;
        eff_addr   = '0;
        addr_space = SP_NONE;
        byte_hi    = 1'b0;
        ptr_we     = 1'b0;
        ptr_wsel   = '0;
        ptr_wdata  = '0;
        req_err    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ISSUE: begin
                addr_valid = 1'b1;
                eff_addr   = r_addr;
                addr_space = r_space;
                byte_hi    = r_hi;
            end
            ST_WBACK: begin
                ptr_we    = 1'b1;
                ptr_wsel  = r_wsel;
                ptr_wdata = r_wdata;
            end
            ST_REJECT: req_err = 1'b1;
        endcase
    end
endmodule

// File: rtl/ptr_agen_chk.sv
module ptr_agen_chk
    import agen_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 23
) (
    input logic              clk,
    input logic              rst_n,
    input agen_st_e          state,
    input logic [3:0]        cap_mode,
    input logic [1:0]        cap_sel,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] eff_addr,
    input logic [1:0]        addr_space,
    input logic              byte_hi,
    input logic              ptr_we,
    input logic [1:0]        ptr_wsel,
    input logic [PTR_W-1:0]  ptr_wdata,
    input logic              req_err
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!addr_valid && !ptr_we && !req_err && eff_addr == '0));

    p_ptr_modes_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && cap_mode <= 4'd4) |-> (addr_space == 2'(SP_DATA)));

    p_disp_not_x_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && cap_mode == 4'(M_DISP)) |-> (cap_sel != PSEL_X));

    p_predec_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && cap_mode == 4'(M_PREDEC)) |->
            (ptr_wdata == $past(eff_addr[PTR_W-1:0]) && ptr_wsel == cap_sel));

    p_postinc_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && cap_mode == 4'(M_POSTINC)) |->
            (ptr_wdata == $past(eff_addr[PTR_W-1:0]) + PTR_W'(1)));

    p_io_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_space == 2'(SP_IO)) |-> (eff_addr < ADDR_W'(64)));

    p_hi_only_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_hi |-> (addr_valid && addr_space == 2'(SP_PROG)));

    p_prog_wb_z_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && cap_mode >= 4'd6) |-> (ptr_wsel == PSEL_Z));

    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> !addr_valid);

    p_wb_after_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |-> $past(addr_valid));

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WBACK || state == ST_REJECT) |=> (state == ST_IDLE));

    p_err_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!addr_valid && !ptr_we && !$past(req_err)));
endmodule

bind ptr_agen ptr_agen_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .cap_mode   (r_mode),
    .cap_sel    (r_sel),
    .addr_valid (addr_valid),
    .eff_addr   (eff_addr),
    .addr_space (addr_space),
    .byte_hi    (byte_hi),
    .ptr_we     (ptr_we),
    .ptr_wsel   (ptr_wsel),
    .ptr_wdata  (ptr_wdata),
    .req_err    (req_err)
);

// File: tb/ptr_agen_tb_top.sv
module ptr_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  ptr_sel = '0;
    logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0, direct_addr = '0;
    logic [5:0]  disp = '0, io_addr = '0;
    logic [7:0]  ext_reg = '0;
    logic        addr_valid, byte_hi, ptr_we, req_err;
    logic [22:0] eff_addr;
    logic [1:0]  addr_space, ptr_wsel;
    logic [15:0] ptr_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // expected values
    bit          e_ok, e_hi, e_wb;
    int unsigned e_addr, e_wdata;
    int unsigned e_space, e_wsel;

    always #10 clk = ~clk;

    ptr_agen dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .ptr_sel(ptr_sel),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .disp(disp),
        .direct_addr(direct_addr), .io_addr(io_addr), .ext_reg(ext_reg),
        .addr_valid(addr_valid), .eff_addr(eff_addr), .addr_space(addr_space),
        .byte_hi(byte_hi), .ptr_we(ptr_we), .ptr_wsel(ptr_wsel),
        .ptr_wdata(ptr_wdata), .req_err(req_err)
    );

    task automatic check(string tag, int unsigned act, int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic string rtag(int unsigned m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4, 5: return "R6";
            6, 7: return "R7";
            8, 9: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic model();
        int unsigned p;
        int unsigned m = mode;
        int unsigned s = ptr_sel;
        p = (s == 0) ? ptr_x : (s == 1) ? ptr_y : (s == 2) ? ptr_z : 0;
        e_ok = 0; e_hi = 0; e_wb = 0; e_addr = 0; e_wdata = 0; e_space = 0; e_wsel = 0;
        case (m)
            0: begin e_ok = (s != 3); e_addr = p; e_space = 1; end
            1: begin e_ok = (s == 1 || s == 2); e_addr = (p + disp) & 16'hFFFF; e_space = 1; end
            2: begin e_ok = (s != 3); e_addr = (p + 16'hFFFF) & 16'hFFFF; e_space = 1;
                     e_wb = e_ok; e_wsel = s; e_wdata = e_addr; end
            3: begin e_ok = (s != 3); e_addr = p; e_space = 1;
                     e_wb = e_ok; e_wsel = s; e_wdata = (p + 1) & 16'hFFFF; end
            4: begin e_ok = 1; e_addr = direct_addr; e_space = 1; end
            5: begin e_ok = 1; e_addr = io_addr; e_space = 2; end
            6, 7, 8, 9: begin
                e_ok = 1; e_space = 3; e_hi = ptr_z[0];
                e_addr = ((m >= 8) ? (int'(ext_reg) << 15) : 0) | (int'(ptr_z) >> 1);
                if (m == 7 || m == 9) begin
                    e_wb = 1; e_wsel = 2; e_wdata = (ptr_z + 1) & 16'hFFFF;
                end
            end
            default: e_ok = 0;
        endcase
    endtask

    task automatic run_req();
        string t;
        @(negedge clk);
        model();
        t = rtag(mode);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (e_ok) begin
            check({t, "/R9 valid"}, addr_valid, 1);
            check({t, " addr"}, eff_addr, e_addr);
            check({t, " space"}, addr_space, e_space);
            check({t, " byte_hi"}, byte_hi, e_hi);
            check({t, " err"}, req_err, 0);
        end else begin
            check("R11 err", req_err, 1);
            check("R11 valid", addr_valid, 0);
        end
        check({t, "/R9 no early wb"}, ptr_we, 0);
        @(negedge clk);
        check({t, "/R9 valid single"}, addr_valid, 0);
        check({t, "/R9 wb strobe"}, ptr_we, e_wb);
        check({t, " wb sel"}, ptr_wsel, e_wb ? e_wsel : 0);
        check({t, " wb data"}, ptr_wdata, e_wb ? e_wdata : 0);
        check({t, "/R11 err single"}, req_err, 0);
        if (e_wb) begin
            @(negedge clk);
            check({t, "/R1 back idle"}, {addr_valid, ptr_we, req_err}, 0);
        end
    endtask

    task automatic set_req(int m, int s, int x, int y, int z, int d, int dir, int io, int e);
        mode = 4'(m); ptr_sel = 2'(s); ptr_x = 16'(x); ptr_y = 16'(y); ptr_z = 16'(z);
        disp = 6'(d); direct_addr = 16'(dir); io_addr = 6'(io); ext_reg = 8'(e);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check("R1 valid", addr_valid, 0);
        check("R1 outs", {eff_addr, addr_space, byte_hi, ptr_we, ptr_wsel, ptr_wdata, req_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {addr_valid, ptr_we, req_err, addr_space}, 0);

        // directed corner cases
        set_req(0, 0, 'h1234, 'h5678, 'h9ABC, 0, 0, 0, 0);    run_req(); // R2 X
        set_req(0, 2, 'h1234, 'h5678, 'h9ABC, 0, 0, 0, 0);    run_req(); // R2 Z
        set_req(1, 1, 0, 'hFFF0, 0, 63, 0, 0, 0);             run_req(); // R3 wrap
        set_req(1, 0, 'h0100, 0, 0, 5, 0, 0, 0);              run_req(); // R3 X illegal
        set_req(2, 1, 0, 'h0000, 0, 0, 0, 0, 0);              run_req(); // R4 wrap
        set_req(3, 0, 'hFFFF, 0, 0, 0, 0, 0, 0);              run_req(); // R5 wrap
        set_req(4, 3, 0, 0, 0, 0, 'hBEEF, 0, 0);              run_req(); // R6 direct
        set_req(5, 0, 0, 0, 0, 0, 0, 63, 0);                  run_req(); // R6 io
        set_req(6, 0, 0, 0, 'h8001, 0, 0, 0, 'hA5);           run_req(); // R7 ext ignored
        set_req(9, 1, 0, 0, 'hFFFF, 0, 0, 0, 'hC3);           run_req(); // R8 ext + wrap
        set_req(12, 0, 0, 0, 0, 0, 0, 0, 0);                  run_req(); // R11 reserved
        set_req(3, 3, 1, 2, 3, 0, 0, 0, 0);                   run_req(); // R11 sel 3

        // R10: req held high through the issue cycle is ignored
        set_req(4, 0, 0, 0, 0, 0, 'h0042, 0, 0);
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        check("R10 first accepted", addr_valid, 1);
        check("R10 first addr", eff_addr, 'h42);
        set_req(5, 0, 0, 0, 0, 0, 0, 7, 0);
        @(negedge clk);
        req = 1'b0;
        check("R10 second ignored", {addr_valid, ptr_we, req_err}, 0);
        @(negedge clk);
        check("R10 still idle", {addr_valid, req_err}, 0);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            set_req($urandom_range(15), $urandom_range(3), $urandom, $urandom, $urandom,
                    $urandom, $urandom, $urandom, $urandom);
            run_req();
        end

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule